// File: doc/BRIEF.md
# Read-Key Nonvolatile Command Detector

This block watches the access stream of a small SRAM. It picks out a hidden command that is written as six read cycles in a row to fixed 13-bit addresses. The first five addresses are the same for both commands. The sixth address picks the command: `0F0F` asks for a nonvolatile store and `0F0E` asks for a nonvolatile recall. When a key completes, the block raises a one-cycle trigger for the matching engine. During the sixth access it also raises a flag that tells the data-bus driver to float the bus for that cycle. The SRAM array and the store and recall engines sit outside this block.

An access is a clock cycle with `cyc_stb` and `chip_sel` both high. Non-access cycles are invisible to the matcher. Any read to the wrong address stops the match. A write access (`wr_n` low) also stops it. There is one exception: a read to address `0000` always counts as the first step of a new attempt.

The matcher is a state machine with six states:
- `ST_IDLE`: nothing matched.
- `ST_K1` to `ST_K5`: that many leading key reads have been seen.

It has the following transitions:
- **advance**: a read that matches the next key address moves to the next state.
- **complete**: from `ST_K5`, a read at `0F0F` or `0F0E` returns to `ST_IDLE` and fires a trigger.
- **restart**: any other read goes to `ST_K1` if its address is `0000`, and to `ST_IDLE` otherwise.
- **cancel**: a write access goes to `ST_IDLE`.
- **hold**: a non-access cycle keeps the current state.

Top module: `nvseq_detect`

## Requirements
- R1: After reset, `store_pulse`, `recall_pulse` and `dq_hiz` are all 0 and no key step is matched.
- R2: Six consecutive read accesses at hex `0000`, `1555`, `0AAA`, `1FFF`, `10F0`, `0F0F` raise `store_pulse` for exactly the one clock cycle that follows the sixth access edge. `recall_pulse` stays 0.
- R3: The same five leading addresses followed by a read at `0F0E` raise `recall_pulse` for exactly one cycle, one edge after the sixth access. `store_pulse` stays 0.
- R4: `dq_hiz` is 1 combinationally during the sixth access of a completed key, and 0 in every other cycle.
- R5: An access with `wr_n` = 0, at any address, clears the match. It can never complete a key.
- R6: A read whose address does not match the expected key step restarts matching. If that address is `0000`, it counts as step one of a new attempt.
- R7: Cycles where `cyc_stb` or `chip_sel` is 0 neither advance nor clear the match.
- R8: After a completed key the match is cleared. A further final-address read alone fires nothing.
- R9: `store_pulse` and `recall_pulse` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_stb | input | 1 | Marks a cycle that carries an SRAM access |
| chip_sel | input | 1 | Chip enable, active high |
| wr_n | input | 1 | Write strobe, active low; 1 means the access is a read |
| addr | input | 13 | Access address |
| store_pulse | output | 1 | One-cycle store trigger |
| recall_pulse | output | 1 | One-cycle recall trigger |
| dq_hiz | output | 1 | Forces the data bus to high impedance during the completing access |

## Verification
Two things can happen in the same clock cycle. A registered trigger from one key may be raised while the first address of the next key is presented. The bench provokes this by sending keys back to back with no idle cycle between them. Each key's trigger must appear while the next key's `0000` read is accepted as step one. The second key must still fire on its own sixth access. A reference step counter in the bench predicts both events independently.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

    localparam int NV_ADDR_W = 13;
    localparam int NV_KEY_LEN = 6;
    localparam int NV_PREFIX = NV_KEY_LEN - 1;

    localparam logic [NV_ADDR_W-1:0] NV_TAIL_STORE  = 13'h0F0F;
    localparam logic [NV_ADDR_W-1:0] NV_TAIL_RECALL = 13'h0F0E;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_K1   = 3'd1,
        ST_K2   = 3'd2,
        ST_K3   = 3'd3,
        ST_K4   = 3'd4,
        ST_K5   = 3'd5
    } nv_state_e;

    // Shared leading addresses of both keys; the step order is behaviour.
    function automatic logic [NV_ADDR_W-1:0] nv_prefix_key(input int idx);
        logic [NV_ADDR_W-1:0] k;
        case (idx)
            0: k = 13'h0000;
            1: k = 13'h1555;
            2: k = 13'h0AAA;
            3: k = 13'h1FFF;
            4: k = 13'h10F0;
            default: k = '0;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/nvseq_addr_cmp.sv
module nvseq_addr_cmp
    import nvseq_pkg::*;
#(
    parameter int ADDR_W = NV_ADDR_W,
    parameter int PREFIX = NV_PREFIX
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [PREFIX-1:0] prefix_hit,
    output logic              tail_store,
    output logic              tail_recall
);

    // One comparator lane per leading key step.
    for (genvar g = 0; g < PREFIX; g++) begin : g_lane
        assign prefix_hit[g] = (addr == nv_prefix_key(g));
    end

    assign tail_store  = (addr == NV_TAIL_STORE);
    assign tail_recall = (addr == NV_TAIL_RECALL);

    always_comb begin
        assert_tails_exclusive_R9: assert (!(tail_store && tail_recall));
    end

endmodule

// File: rtl/nvseq_fsm.sv
module nvseq_fsm
    import nvseq_pkg::*;
#(
    parameter int ADDR_W = NV_ADDR_W,
    parameter int PREFIX = NV_PREFIX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_stb,
    input  logic              chip_sel,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PREFIX-1:0] prefix_hit,
    input  logic              tail_store,
    input  logic              tail_recall,
    output logic              done_store,
    output logic              done_recall
);

    nv_state_e state, state_nx, restart_st;
    logic      access;
    logic      rd_access;

    assign access     = cyc_stb && chip_sel;
    assign rd_access  = access && wr_n;
    assign restart_st = prefix_hit[0] ? ST_K1 : ST_IDLE;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: hold, cancel, advance, complete, restart.
    always_comb begin
        state_nx = state;
        if (!access) begin
            state_nx = state;
        end else if (!wr_n) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = restart_st;
                ST_K1:   state_nx = prefix_hit[1] ? ST_K2 : restart_st;
                ST_K2:   state_nx = prefix_hit[2] ? ST_K3 : restart_st;
                ST_K3:   state_nx = prefix_hit[3] ? ST_K4 : restart_st;
                ST_K4:   state_nx = prefix_hit[4] ? ST_K5 : restart_st;
                ST_K5:   state_nx = (tail_store || tail_recall) ? ST_IDLE : restart_st;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Completion decode.
    always_comb begin
        done_store  = 1'b0;
        done_recall = 1'b0;
        if (rd_access && state == ST_K5) begin
            done_store  = tail_store;
            done_recall = tail_recall;
        end
    end

    assert_write_cancels_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !wr_n) |=> (state == ST_IDLE));

    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!access) |=> $stable(state));

    assert_zero_is_step_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_access && addr == '0) |=> (state == ST_K1));

    assert_clear_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_store || done_recall) |=> (state == ST_IDLE));

endmodule

// File: rtl/nvseq_out.sv
module nvseq_out (
    input  logic clk,
    input  logic rst_n,
    input  logic done_store,
    input  logic done_recall,
    output logic store_pulse,
    output logic recall_pulse,
    output logic dq_hiz
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_pulse  <= 1'b0;
            recall_pulse <= 1'b0;
        end else begin
            store_pulse  <= done_store;
            recall_pulse <= done_recall;
        end
    end

    assign dq_hiz = done_store || done_recall;

    assert_hiz_then_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_hiz |=> (store_pulse ^ recall_pulse));

    assert_store_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        store_pulse |=> !store_pulse);

    assert_recall_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        recall_pulse |=> !recall_pulse);

    assert_triggers_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_pulse, recall_pulse}));

endmodule

// File: rtl/nvseq_detect.sv
module nvseq_detect
    import nvseq_pkg::*;
#(
    parameter int ADDR_W = NV_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_stb,
    input  logic              chip_sel,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              store_pulse,
    output logic              recall_pulse,
    output logic              dq_hiz
);

    localparam int PREFIX = NV_PREFIX;

    logic [PREFIX-1:0] prefix_hit;
    logic              tail_store, tail_recall;
    logic              done_store, done_recall;

    nvseq_addr_cmp #(.ADDR_W(ADDR_W), .PREFIX(PREFIX)) u_cmp (
        .addr        (addr),
        .prefix_hit  (prefix_hit),
        .tail_store  (tail_store),
        .tail_recall (tail_recall)
    );

    nvseq_fsm #(.ADDR_W(ADDR_W), .PREFIX(PREFIX)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_stb     (cyc_stb),
        .chip_sel    (chip_sel),
        .wr_n        (wr_n),
        .addr        (addr),
        .prefix_hit  (prefix_hit),
        .tail_store  (tail_store),
        .tail_recall (tail_recall),
        .done_store  (done_store),
        .done_recall (done_recall)
    );

    nvseq_out u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .done_store   (done_store),
        .done_recall  (done_recall),
        .store_pulse  (store_pulse),
        .recall_pulse (recall_pulse),
        .dq_hiz       (dq_hiz)
    );

endmodule

// File: tb/nvseq_detect_bench.sv
`timescale 1ns/1ps
module nvseq_detect_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_stb = 1'b0, chip_sel = 1'b0, wr_n = 1'b1;
    logic [12:0] addr = '0;
    logic        store_pulse, recall_pulse, dq_hiz;

    int n_tests = 0;
    int n_fail = 0;

    // Reference model: number of matched key steps plus pending triggers.
    int m_step = 0;
    bit exp_s = 0, exp_r = 0;

    always #5 clk = ~clk;

    nvseq_detect u_nvseq_detect (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .chip_sel(chip_sel),
        .wr_n(wr_n), .addr(addr), .store_pulse(store_pulse),
        .recall_pulse(recall_pulse), .dq_hiz(dq_hiz)
    );

    function automatic logic [12:0] key_at(input int i, input bit rec);
        case (i)
            0: return 13'h0000;
            1: return 13'h1555;
            2: return 13'h0AAA;
            3: return 13'h1FFF;
            4: return 13'h10F0;
            default: return rec ? 13'h0F0E : 13'h0F0F;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock cycle: check last cycle's triggers, drive, check dq_hiz.
    task automatic cyc(input bit stb, input bit sel, input bit wn,
                       input logic [12:0] a, input string tag);
        bit hz;
        @(negedge clk);
        chk(store_pulse == exp_s, {"R2 store ", tag}, store_pulse, exp_s);
        chk(recall_pulse == exp_r, {"R3 recall ", tag}, recall_pulse, exp_r);
        chk(!(store_pulse && recall_pulse), {"R9 ", tag}, store_pulse + recall_pulse, 1);
        cyc_stb = stb; chip_sel = sel; wr_n = wn; addr = a;
        #1;
        hz = 0; exp_s = 0; exp_r = 0;
        if (stb && sel) begin
            if (!wn) m_step = 0;
            else if (m_step == 5 && (a == 13'h0F0F || a == 13'h0F0E)) begin
                hz = 1; exp_s = (a == 13'h0F0F); exp_r = (a == 13'h0F0E); m_step = 0;
            end else if (m_step < 5 && a == key_at(m_step, 0)) m_step++;
            else m_step = (a == 13'h0000) ? 1 : 0;
        end
        chk(dq_hiz == hz, {"R4 hiz ", tag}, dq_hiz, hz);
    endtask

    task automatic run_key(input bit rec, input string tag);
        for (int i = 0; i < 6; i++) cyc(1, 1, 1, key_at(i, rec), tag);
    endtask

    initial begin : watchdog
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(store_pulse == 0 && recall_pulse == 0 && dq_hiz == 0, "R1 reset outputs",
            {store_pulse, recall_pulse, dq_hiz}, 0);
        rst_n = 1'b1;
        cyc(0, 0, 1, 13'h0F0F, "R1 idle");
        // R1: a lone final address right after reset fires nothing.
        cyc(1, 1, 1, 13'h0F0F, "R1 no match after reset");

        run_key(0, "R2 plain store");
        run_key(1, "R3 plain recall");
        // Back-to-back keys: trigger overlaps next step one.
        run_key(0, "R2 back to back");
        run_key(1, "R3 back to back");
        run_key(0, "R2 back to back tail");
        cyc(0, 1, 1, 13'h0000, "flush");

        // R8: repeating the final address after completion fires nothing.
        cyc(1, 1, 1, 13'h0F0F, "R8 repeat tail");
        cyc(1, 1, 1, 13'h0F0E, "R8 repeat tail");

        // R6: a second 0000 restarts as step one.
        cyc(1, 1, 1, 13'h0000, "R6 double zero");
        run_key(0, "R6 after double zero");

        // Near-exhaustive sweep: prefix length x disturbance x completion kind.
        for (int k = 0; k < 6; k++) begin
            for (int d = 0; d < 5; d++) begin
                for (int rec = 0; rec < 2; rec++) begin
                    for (int i = 0; i < k; i++) cyc(1, 1, 1, key_at(i, rec[0]), "sweep prefix");
                    case (d)
                        0: cyc(1, 1, 1, 13'h0123, "R6 wrong address");
                        1: cyc(1, 1, 1, 13'h0000, "R6 zero restart");
                        2: cyc(1, 1, 0, key_at(k, rec[0]), "R5 write cancels");
                        3: cyc(1, 0, 1, 13'h1ABC, "R7 deselected");
                        default: cyc(0, 1, 1, 13'h1ABC, "R7 no strobe");
                    endcase
                    for (int i = k; i < 6; i++) cyc(1, 1, 1, key_at(i, rec[0]), "R7 continuation");
                    run_key(rec[0], "sweep fresh key");
                end
            end
        end

        // Final-address sweep after a full prefix.
        for (int t = 0; t < 8; t++) begin
            logic [12:0] tail;
            case (t)
                0: tail = 13'h0F0F;  1: tail = 13'h0F0E;
                2: tail = 13'h0F0D;  3: tail = 13'h0F1F;
                4: tail = 13'h1F0F;  5: tail = 13'h0000;
                6: tail = 13'h0E0F;  default: tail = 13'h0F0C;
            endcase
            for (int i = 0; i < 5; i++) cyc(1, 1, 1, key_at(i, 0), "tail prefix");
            cyc(1, 1, 1, tail, "R6 tail sweep");
            cyc(1, 1, 0, 13'h0000, "R5 tail flush");
        end
        cyc(0, 0, 1, 13'h0000, "end flush");
        cyc(0, 0, 1, 13'h0000, "end flush");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule